// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall time as a running count of seconds. A slow reference clock, presented as a one-cycle enable pulse `ref_tick` on the block clock, drives a 20-bit prescaler that reloads itself. Each time the prescaler expires it issues one tick. The tick advances a 32-bit seconds counter and sets a seconds flag. A 32-bit alarm compare value sets an alarm flag on the tick that moves the counter off the stored value. Software therefore stores N-1 to be alerted at second N.

Software reaches the block over a small 16-bit register bus. The counter, the reload value and the alarm value can only be changed while a configuration bit is set. Writes made in that window are held in staging registers. They take effect a fixed number of cycles after the configuration bit is cleared, and an idle status bit reports when that is done. The timing state sits in a backup reset domain, so a system reset leaves it intact. The flags, enables, configuration bit and read-synchronised bit sit in the system domain.

Top module: `rtc_seconds`

## Requirements
- R1: Each 1 on `ref_tick` steps the prescaler, and the counter increments by one on every (reload+1)-th pulse.
- R2: Committing a new reload value restarts the prescaler count from that value, so the next tick arrives after exactly reload+1 further pulses.
- R3: Addresses: 0 control, 1 interrupt enable, 2/3 reload high/low, 4/5 counter high/low, 6/7 alarm high/low. Reload high keeps only bits 3:0 and reads zero above them. A commit changes only the halves written during configuration.
- R4: Writes to addresses 2..7 are ignored unless control bit 0 (configuration) is 1. Setting bit 0 is ignored while a commit is in progress.
- R5: Clearing control bit 0 while it is 1 makes control bit 1 (idle) read 0 for three cycles. The staged values appear, and idle returns to 1, on the third clock edge after that write.
- R6: Control bit 3 (seconds flag) sets on every tick. Control bit 4 (alarm flag) sets on a tick taken while the counter equals the alarm value.
- R7: Writing 0 to control bit 2, 3 or 4 clears that bit, and writing 1 leaves it unchanged. A set in the same cycle wins over a clear.
- R8: `irq_sec` is the seconds flag ANDed with enable bit 0, and `irq_alarm` is the alarm flag ANDed with enable bit 1.
- R9: Control bit 2 (synchronised) is 0 after a system reset and sets on the next `ref_tick` pulse.
- R10: A system reset clears the configuration bit, the flags, the enables and the synchronised bit, and leaves the counter, reload and alarm unchanged. A backup reset sets the counter to 0, the reload to 32767 and the alarm to 0xFFFFFFFF.
- R11: The counter wraps from 0xFFFFFFFF to 0 on a tick, and the wrap sets no flag other than the seconds flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Active-low system reset |
| bkp_rst_n | input | 1 | Active-low backup-domain reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, sampled with bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
Control and enable writes are visible one edge after the write, and so are the flags and the counter after the tick pulse that causes them. The interrupt outputs and read data follow combinationally. Staged timing values appear three edges after the write that clears the configuration bit. The bench reads idle and the counter immediately after that write and again after the second and third following edges. Reference pulses are one cycle wide and driven on falling edges, so the bench knows exactly which pulse carries the tick. It reads the registers one time step after a falling edge, clear of any active edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int ADDR_W = 3;
   // register addresses
   localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] RA_IEN    = 3'd1;
   localparam logic [ADDR_W-1:0] RA_RLD_HI = 3'd2;
   localparam logic [ADDR_W-1:0] RA_RLD_LO = 3'd3;
   localparam logic [ADDR_W-1:0] RA_CNT_HI = 3'd4;
   localparam logic [ADDR_W-1:0] RA_CNT_LO = 3'd5;
   localparam logic [ADDR_W-1:0] RA_ALM_HI = 3'd6;
   localparam logic [ADDR_W-1:0] RA_ALM_LO = 3'd7;
   // control register bits
   localparam int CB_CFG   = 0;
   localparam int CB_IDLE  = 1;
   localparam int CB_SYNC  = 2;
   localparam int CB_FLAG0 = 3;
   // flags
   localparam int NFLAG  = 2;
   localparam int FL_SEC = 0;
   localparam int FL_ALM = 1;
   // staged halves, index = address - RA_RLD_HI
   localparam int NSTAGE    = 6;
   localparam int SI_RLD_HI = 0;
   localparam int SI_RLD_LO = 1;
   localparam int SI_CNT_HI = 2;
   localparam int SI_CNT_LO = 3;
   localparam int SI_ALM_HI = 4;
   localparam int SI_ALM_LO = 5;
endpackage

// File: rtl/rtc_commit.sv
module rtc_commit
   import rtc_pkg::*;
#(
   parameter int BUS_W      = 16,
   parameter int COMMIT_CYC = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            wr_addr_i,
   input  logic [BUS_W-1:0]             wr_data_i,
   output logic                         cfg_o,
   output logic                         idle_o,
   output logic                         commit_o,
   output logic [NSTAGE-1:0]            pend_o,
   output logic [NSTAGE-1:0][BUS_W-1:0] stage_o
);
   localparam int CW = $clog2(COMMIT_CYC + 1);

   logic                         cfg_q;
   logic [CW-1:0]                busy_q;
   logic [NSTAGE-1:0]            pend_q;
   logic [NSTAGE-1:0][BUS_W-1:0] stage_q;
   logic                         ctrl_wr;
   logic                         leave;

   assign ctrl_wr = wr_en_i && (wr_addr_i == RA_CTRL);
   assign leave   = ctrl_wr && !wr_data_i[CB_CFG] && cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= 1'b0;
      end else if (ctrl_wr) begin
         if (!wr_data_i[CB_CFG]) cfg_q <= 1'b0;
         else if (busy_q == '0) cfg_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else if (leave) begin
         busy_q <= CW'(COMMIT_CYC);
      end else if (busy_q != '0) begin
         busy_q <= busy_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         pend_q  <= '0;
      end else if (commit_o) begin
         pend_q <= '0;
      end else if (wr_en_i && cfg_q) begin
         for (int i = 0; i < NSTAGE; i++) begin
            if (wr_addr_i == RA_RLD_HI + ADDR_W'(i)) begin
               stage_q[i] <= wr_data_i;
               pend_q[i]  <= 1'b1;
            end
         end
      end
   end

   assign cfg_o    = cfg_q;
   assign idle_o   = (busy_q == '0);
   assign commit_o = (busy_q == CW'(1));
   assign pend_o   = pend_q;
   assign stage_o  = stage_q;

   // R5
   commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_q) |-> !idle_o);
   // R5
   commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> idle_o);
   // R4
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data_i[CB_CFG] && !idle_o) |=> !cfg_q);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int                 PRESC_W      = 20,
   parameter logic [PRESC_W-1:0] RESET_RELOAD = PRESC_W'(32767)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick_i,
   input  logic               load_i,
   input  logic [PRESC_W-1:0] load_val_i,
   output logic [PRESC_W-1:0] reload_o,
   output logic               tick_o
);
   logic [PRESC_W-1:0] rld_q;
   logic [PRESC_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_q <= RESET_RELOAD;
         cnt_q <= RESET_RELOAD;
      end else if (load_i) begin
         rld_q <= load_val_i;
         cnt_q <= load_val_i;
      end else if (ref_tick_i) begin
         cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
      end
   end

   assign tick_o   = ref_tick_i && !load_i && (cnt_q == '0);
   assign reload_o = rld_q;

   // R2
   reload_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)) && (rld_q == $past(load_val_i)));
   // R1
   presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick_i && !load_i && cnt_q != '0) |=> cnt_q == PRESC_W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int CNT_W = 32,
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             commit_i,
   input  logic [1:0]       cnt_pend_i,
   input  logic [1:0]       alm_pend_i,
   input  logic [BUS_W-1:0] cnt_hi_i,
   input  logic [BUS_W-1:0] cnt_lo_i,
   input  logic [BUS_W-1:0] alm_hi_i,
   input  logic [BUS_W-1:0] alm_lo_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] alarm_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] alm_q, alm_d;

   function automatic logic [CNT_W-1:0] merge_halves(
      input logic [CNT_W-1:0] cur,
      input logic [1:0]       pend,
      input logic [BUS_W-1:0] hi,
      input logic [BUS_W-1:0] lo);
      logic [CNT_W-1:0] r;
      r = cur;
      if (pend[0]) r[BUS_W-1:0]     = lo;
      if (pend[1]) r[CNT_W-1:BUS_W] = hi;
      return r;
   endfunction

   always_comb begin
      cnt_d = cnt_q;
      alm_d = alm_q;
      if (commit_i && cnt_pend_i != 2'b00)
         cnt_d = merge_halves(cnt_q, cnt_pend_i, cnt_hi_i, cnt_lo_i);
      else if (tick_i)
         cnt_d = cnt_q + 1'b1;
      if (commit_i)
         alm_d = merge_halves(alm_q, alm_pend_i, alm_hi_i, alm_lo_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         alm_q <= '1;
      end else begin
         cnt_q <= cnt_d;
         alm_q <= alm_d;
      end
   end

   assign count_o = cnt_q;
   assign alarm_o = alm_q;
   assign hit_o   = tick_i && (cnt_q == alm_q);

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !commit_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));
   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !commit_i) |=> $stable(count_o));
   // R3
   half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && cnt_pend_i == 2'b01) |=> count_o[CNT_W-1:BUS_W] == $past(count_o[CNT_W-1:BUS_W]));
endmodule

// File: rtl/rtc_flag.sv
module rtc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_wr_i,
   input  logic wr_bit_i,
   input  logic ien_i,
   output logic flag_o,
   output logic irq_o
);
   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q <= 1'b0;
      else if (set_i)                 q <= 1'b1;
      else if (clr_wr_i && !wr_bit_i) q <= 1'b0;
   end

   assign flag_o = q;
   assign irq_o  = q & ien_i;

   // R7
   w1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_i && wr_bit_i && !set_i) |=> flag_o == $past(flag_o));
   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
   import rtc_pkg::*;
#(
   parameter int          BUS_W        = 16,
   parameter int          CNT_W        = 32,
   parameter int          PRESC_W      = 20,
   parameter int          COMMIT_CYC   = 3,
   parameter logic [31:0] RESET_RELOAD = 32'd32767
) (
   input  logic              clk,
   input  logic              sys_rst_n,
   input  logic              bkp_rst_n,
   input  logic              ref_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_sec,
   output logic              irq_alarm
);
   localparam int RH_W = PRESC_W - BUS_W;

   if (CNT_W != 2 * BUS_W) begin : g_bad_cnt_w
      $error("CNT_W must be twice BUS_W");
   end
   if (PRESC_W <= BUS_W || PRESC_W > 2 * BUS_W) begin : g_bad_presc_w
      $error("PRESC_W must lie above BUS_W and at most 2*BUS_W");
   end
   if (COMMIT_CYC < 1) begin : g_bad_commit
      $error("COMMIT_CYC must be at least 1");
   end
   if ((64'(RESET_RELOAD) >> PRESC_W) != 64'd0) begin : g_bad_reload
      $error("RESET_RELOAD does not fit in PRESC_W bits");
   end

   logic                         wr_en, ctrl_wr;
   logic                         cfg, idle, commit;
   logic [NSTAGE-1:0]            pend;
   logic [NSTAGE-1:0][BUS_W-1:0] stage;
   logic [PRESC_W-1:0]           reload, rld_new;
   logic                         rld_load, tick, alarm_hit;
   logic [CNT_W-1:0]             count, alarm;
   logic [NFLAG-1:0]             ien_q, flag_set, flag_q, flag_irq;
   logic                         synced_q;
   logic                         unused_rld_hi;

   assign wr_en   = bus_sel && bus_wr;
   assign ctrl_wr = wr_en && (bus_addr == RA_CTRL);

   rtc_commit #(.BUS_W(BUS_W), .COMMIT_CYC(COMMIT_CYC)) u_commit (
      .clk       (clk),
      .rst_n     (sys_rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (bus_addr),
      .wr_data_i (bus_wdata),
      .cfg_o     (cfg),
      .idle_o    (idle),
      .commit_o  (commit),
      .pend_o    (pend),
      .stage_o   (stage)
   );

   assign rld_load = commit && (pend[SI_RLD_HI] || pend[SI_RLD_LO]);
   assign rld_new  = {pend[SI_RLD_HI] ? stage[SI_RLD_HI][RH_W-1:0] : reload[PRESC_W-1:BUS_W],
                      pend[SI_RLD_LO] ? stage[SI_RLD_LO]            : reload[BUS_W-1:0]};
   assign unused_rld_hi = ^stage[SI_RLD_HI][BUS_W-1:RH_W];

   rtc_prescaler #(.PRESC_W(PRESC_W), .RESET_RELOAD(RESET_RELOAD[PRESC_W-1:0])) u_presc (
      .clk        (clk),
      .rst_n      (bkp_rst_n),
      .ref_tick_i (ref_tick),
      .load_i     (rld_load),
      .load_val_i (rld_new),
      .reload_o   (reload),
      .tick_o     (tick)
   );

   rtc_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
      .clk        (clk),
      .rst_n      (bkp_rst_n),
      .tick_i     (tick),
      .commit_i   (commit),
      .cnt_pend_i ({pend[SI_CNT_HI], pend[SI_CNT_LO]}),
      .alm_pend_i ({pend[SI_ALM_HI], pend[SI_ALM_LO]}),
      .cnt_hi_i   (stage[SI_CNT_HI]),
      .cnt_lo_i   (stage[SI_CNT_LO]),
      .alm_hi_i   (stage[SI_ALM_HI]),
      .alm_lo_i   (stage[SI_ALM_LO]),
      .count_o    (count),
      .alarm_o    (alarm),
      .hit_o      (alarm_hit)
   );

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n)                               ien_q <= '0;
      else if (wr_en && bus_addr == RA_IEN)         ien_q <= bus_wdata[NFLAG-1:0];
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n)                               synced_q <= 1'b0;
      else if (ref_tick)                            synced_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[CB_SYNC])      synced_q <= 1'b0;
   end

   assign flag_set[FL_SEC] = tick;
   assign flag_set[FL_ALM] = alarm_hit;

   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      rtc_flag u_flag (
         .clk      (clk),
         .rst_n    (sys_rst_n),
         .set_i    (flag_set[f]),
         .clr_wr_i (ctrl_wr),
         .wr_bit_i (bus_wdata[CB_FLAG0+f]),
         .ien_i    (ien_q[f]),
         .flag_o   (flag_q[f]),
         .irq_o    (flag_irq[f])
      );
   end

   assign irq_sec   = flag_irq[FL_SEC];
   assign irq_alarm = flag_irq[FL_ALM];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CTRL: begin
            bus_rdata[CB_CFG]  = cfg;
            bus_rdata[CB_IDLE] = idle;
            bus_rdata[CB_SYNC] = synced_q;
            bus_rdata[CB_FLAG0+NFLAG-1:CB_FLAG0] = flag_q;
         end
         RA_IEN:    bus_rdata[NFLAG-1:0] = ien_q;
         RA_RLD_HI: bus_rdata[RH_W-1:0]  = reload[PRESC_W-1:BUS_W];
         RA_RLD_LO: bus_rdata = reload[BUS_W-1:0];
         RA_CNT_HI: bus_rdata = count[CNT_W-1:BUS_W];
         RA_CNT_LO: bus_rdata = count[BUS_W-1:0];
         RA_ALM_HI: bus_rdata = alarm[CNT_W-1:BUS_W];
         RA_ALM_LO: bus_rdata = alarm[BUS_W-1:0];
         default:   bus_rdata = '0;
      endcase
   end

   // R9
   sync_set_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ref_tick |=> synced_q);
   // R6
   alarm_hit_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !bkp_rst_n)
      (tick && count == alarm) |=> flag_q[FL_ALM]);
endmodule

// File: tb/sim_rtc_seconds.sv
module sim_rtc_seconds;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic        bkp_rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        irq_sec, irq_alarm;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rtc_seconds u0 (
      .clk       (clk),
      .sys_rst_n (sys_rst_n),
      .bkp_rst_n (bkp_rst_n),
      .ref_tick  (ref_tick),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_sec   (irq_sec),
      .irq_alarm (irq_alarm)
   );

   localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_RH = 3'd2, A_RL = 3'd3,
                          A_CH = 3'd4, A_CL = 3'd5, A_AH = 3'd6, A_AL = 3'd7;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd32(input logic [2:0] hi_a, output logic [31:0] v);
      logic [15:0] h, l;
      rd(hi_a, h);
      rd(hi_a + 3'd1, l);
      v = {h, l};
   endtask

   // flags and synced bit written as 1 so they are left alone
   task automatic cfg_enter(); wr(A_CTRL, 16'h001D); endtask
   task automatic cfg_leave(); wr(A_CTRL, 16'h001C); endtask
   task automatic commit_wait(); repeat (3) @(negedge clk); endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [15:0] d; logic [31:0] v;
      rd(A_CTRL, d);  check("R10", "ctrl after reset", d, 16'h0002);
      rd32(A_CH, v);  check("R10", "count after reset", v, 32'h0);
      rd32(A_RH, v);  check("R10", "reload after reset", v, 32'd32767);
      rd32(A_AH, v);  check("R10", "alarm after reset", v, 32'hFFFF_FFFF);
      check("R8", "irqs after reset", {irq_sec, irq_alarm}, 2'b00);
      pulse(1);
      rd(A_CTRL, d);  check("R9", "synced after first pulse", d[2], 1'b1);
   endtask

   task automatic t_commit();
      logic [15:0] d; logic [31:0] v;
      cfg_enter();
      wr(A_RH, 16'h0000); wr(A_RL, 16'h0003);
      wr(A_CH, 16'h1234); wr(A_CL, 16'h0005);
      cfg_leave();
      rd(A_CTRL, d); check("R5", "idle right after leave", d[1], 1'b0);
      rd32(A_CH, v); check("R5", "count not yet committed", v, 32'h0);
      repeat (2) @(negedge clk);
      rd(A_CTRL, d); check("R5", "idle two edges later", d[1], 1'b0);
      @(negedge clk);
      rd(A_CTRL, d); check("R5", "idle at third edge", d[1], 1'b1);
      rd32(A_CH, v); check("R5", "count committed", v, 32'h1234_0005);
      rd(A_RL, d);   check("R3", "reload low committed", d, 16'h0003);
   endtask

   task automatic t_presc();
      logic [15:0] d; logic [31:0] v;
      pulse(3);
      rd32(A_CH, v); check("R1", "no tick before reload+1 pulses", v, 32'h1234_0005);
      rd(A_CTRL, d); check("R6", "seconds flag still clear", d[3], 1'b0);
      pulse(1);
      rd32(A_CH, v); check("R1", "tick on pulse reload+1", v, 32'h1234_0006);
      rd(A_CTRL, d); check("R6", "seconds flag set by tick", d[3], 1'b1);
      pulse(4);
      rd32(A_CH, v); check("R1", "second period", v, 32'h1234_0007);
      pulse(2);
      cfg_enter(); wr(A_RL, 16'h0002); cfg_leave(); commit_wait();
      pulse(2);
      rd32(A_CH, v); check("R2", "restart delays tick", v, 32'h1234_0007);
      pulse(1);
      rd32(A_CH, v); check("R2", "tick after restart", v, 32'h1234_0008);
   endtask

   task automatic t_ignore();
      logic [15:0] d; logic [31:0] v;
      wr(A_CL, 16'hAAAA);
      rd32(A_CH, v); check("R4", "write outside config ignored", v, 32'h1234_0008);
      cfg_enter();
      wr(A_CL, 16'h00FF); wr(A_RH, 16'hFFFF);
      cfg_leave();
      wr(A_CTRL, 16'h001D);
      @(negedge clk);
      rd(A_CTRL, d); check("R4", "config set ignored while busy", d[0], 1'b0);
      rd32(A_CH, v); check("R3", "only low half changed", v, 32'h1234_00FF);
      rd(A_RH, d);   check("R3", "reload high keeps 4 bits", d, 16'h000F);
      rd(A_RL, d);   check("R3", "reload low kept", d, 16'h0002);
   endtask

   task automatic t_flags();
      logic [15:0] d;
      check("R8", "irq_sec masked", irq_sec, 1'b0);
      wr(A_IEN, 16'h0001);
      check("R8", "irq_sec enabled", irq_sec, 1'b1);
      wr(A_CTRL, 16'h001C);
      rd(A_CTRL, d); check("R7", "write 1 keeps flag", d[3], 1'b1);
      wr(A_CTRL, 16'h0014);
      rd(A_CTRL, d); check("R7", "write 0 clears flag", d[3], 1'b0);
      check("R8", "irq_sec follows flag", irq_sec, 1'b0);
      wr(A_CTRL, 16'h0018);
      rd(A_CTRL, d); check("R7", "synced cleared by 0", d[2], 1'b0);
      pulse(1);
      rd(A_CTRL, d); check("R9", "synced set again", d[2], 1'b1);
   endtask

   task automatic t_alarm();
      logic [15:0] d; logic [31:0] v;
      cfg_enter();
      wr(A_RH, 16'h0000); wr(A_RL, 16'h0001);
      wr(A_CH, 16'h0000); wr(A_CL, 16'h0005);
      wr(A_AH, 16'h0000); wr(A_AL, 16'h0006);
      cfg_leave(); commit_wait();
      wr(A_CTRL, 16'h0004);
      wr(A_IEN, 16'h0003);
      pulse(2);
      rd32(A_CH, v); check("R1", "count 6", v, 32'h6);
      rd(A_CTRL, d); check("R6", "no alarm reaching stored value", d[4], 1'b0);
      check("R8", "irq_alarm low", irq_alarm, 1'b0);
      pulse(2);
      rd32(A_CH, v); check("R1", "count 7", v, 32'h7);
      rd(A_CTRL, d); check("R6", "alarm leaving stored value", d[4], 1'b1);
      check("R8", "irq_alarm high", irq_alarm, 1'b1);
   endtask

   task automatic t_wrap();
      logic [15:0] d; logic [31:0] v;
      cfg_enter();
      wr(A_CH, 16'hFFFF); wr(A_CL, 16'hFFFF); wr(A_AL, 16'h0064);
      cfg_leave(); commit_wait();
      wr(A_CTRL, 16'h0004);
      pulse(2);
      rd32(A_CH, v); check("R11", "wrap to zero", v, 32'h0);
      rd(A_CTRL, d); check("R11", "flags after wrap", d[4:3], 2'b01);
   endtask

   task automatic t_domains();
      logic [15:0] d; logic [31:0] v;
      pulse(2);
      @(negedge clk); sys_rst_n = 1'b0;
      repeat (3) @(negedge clk); sys_rst_n = 1'b1;
      rd32(A_CH, v); check("R10", "count kept over system reset", v, 32'h1);
      rd(A_RL, d);   check("R10", "reload kept", d, 16'h0001);
      rd32(A_AH, v); check("R10", "alarm kept", v, 32'h64);
      rd(A_CTRL, d); check("R10", "ctrl cleared", d, 16'h0002);
      rd(A_IEN, d);  check("R10", "enables cleared", d, 16'h0000);
      @(negedge clk); bkp_rst_n = 1'b0;
      repeat (2) @(negedge clk); bkp_rst_n = 1'b1;
      rd32(A_CH, v); check("R10", "count after backup reset", v, 32'h0);
      rd32(A_RH, v); check("R10", "reload after backup reset", v, 32'd32767);
      rd32(A_AH, v); check("R10", "alarm after backup reset", v, 32'hFFFF_FFFF);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      sys_rst_n = 1'b1; bkp_rst_n = 1'b1;
      t_reset();
      t_commit();
      t_presc();
      t_ignore();
      t_flags();
      t_alarm();
      t_wrap();
      t_domains();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end
endmodule